// File: doc/BRIEF.md
# Virtual CTA Residency Scheduler

This block decides which thread blocks (CTAs) resident on one GPU core may issue instructions. Admission of new CTAs is limited only by the register and shared-memory budgets of the core and by the number of resident entries the block tracks. That number may be larger than the number of issue slots, which are limited by the program counters and divergence stacks that exist. Every resident CTA is either in an issue slot (active) or parked (inactive). Because parked CTAs keep their registers and shared memory in place, moving a CTA between the two states moves no data.

Each cycle the block looks at per-warp long-latency stall flags. An active CTA whose warps are all stalled is a candidate for eviction. It leaves its issue slot only when a parked CTA is ready to take its place. The replacement is the parked CTA admitted earliest among those that have at least one warp not stalled. The new occupant is held out of the active set for a fixed refill delay. When a CTA completes, its storage and resident entry are released together, and its issue slot is refilled like any other free slot.

The launch unit offers one CTA at a time with its register and shared-memory demand and receives a grant and a resident index. The warp scheduler reads the active set, which has one valid/index pair per issue slot.

Top module: `vt_cta_sched`

## Requirements
- R1: After reset every resident entry is free, every issue slot is empty (all `act_valid` bits low), and a launch whose demand fits both budgets is granted.
- R2: A launch is granted in the same cycle when a resident entry is free and both budgets hold the demand, with equality allowed. `launch_id` is the lowest free resident index. The number of resident CTAs may exceed `N_ACT`.
- R3: A launch is refused when the register sum or the shared-memory sum would exceed its budget, or when no resident entry is free.
- R4: No more than `N_ACT` CTAs occupy issue slots, and no resident index appears in two slots at once.
- R5: Resident CTA i, warp w has its stall flag at `warp_stall` bit i*WPC+w (1 = waiting on a long-latency event). A parked CTA is ready when at least one of its flags is 0. Ready CTAs are promoted oldest-admitted first, into an empty slot or into a slot being given up.
- R6: A running CTA leaves its slot only when all of its warps are stalled and a ready parked CTA exists. It then becomes parked and keeps its storage charged against both budgets.
- R7: After a promotion the slot shows `act_valid` low for exactly `SWAP_CYC` cycles. It then shows the new resident index as valid.
- R8: A `done_valid` pulse for an occupied resident index frees its entry and storage at that clock edge, so a launch in the next cycle may use them. If the CTA held a slot, the slot is refilled by a ready parked CTA or left empty. A done pulse for a parked CTA leaves the active set unchanged.
- R9: When no parked CTA is ready, no slot changes occupant, even if every running CTA is fully stalled.
- R10: At most one promotion happens per cycle. When several slots need one, the lowest-numbered slot is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_req | input | 1 | A CTA is offered for admission this cycle |
| launch_regs | input | REG_W | Register demand of the offered CTA |
| launch_smem | input | SMEM_W | Shared-memory demand of the offered CTA |
| launch_grant | output | 1 | Offered CTA is admitted at the coming edge |
| launch_id | output | RIDW | Resident index given to the admitted CTA |
| warp_stall | input | N_RES*WPC | Per-warp long-latency stall flags, indexed by resident CTA |
| done_valid | input | 1 | A resident CTA has completed |
| done_id | input | RIDW | Resident index of the completed CTA |
| act_valid | output | N_ACT | Issue slot holds a CTA that may issue |
| act_id | output | N_ACT*RIDW | Resident index held by each issue slot |

## Verification
The hardest situation to reach is several slots needing a new occupant in the same cycle while more than one parked CTA is ready. Only that case shows the lowest-slot priority, the oldest-first choice and the one-promotion-per-cycle limit together. The bench gets there by filling every resident entry, recycling one index through completion and relaunch so that admission order no longer follows index order, and then raising the stall flags of both running CTAs in the same cycle. Earlier, the stall flags are held high on every resident CTA for several cycles so that an eviction candidate exists with no ready replacement.

// File: rtl/vt_sched_pkg.sv
// Shared types for the virtual CTA residency scheduler.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package vt_sched_pkg;

    // State of one resident CTA entry.
    typedef enum logic [1:0] {
        RS_FREE  = 2'd0,
        RS_PARK  = 2'd1,
        RS_ISSUE = 2'd2
    } res_state_e;

    // State of one issue slot.
    typedef enum logic [1:0] {
        SL_EMPTY  = 2'd0,
        SL_REFILL = 2'd1,
        SL_RUN    = 2'd2
    } slot_state_e;

endpackage

// File: rtl/vt_budget_gate.sv
// Admission gate: finds the lowest free resident entry and checks the
// register and shared-memory demand against what remains of each budget.
// Keeps running totals of both. Released storage returns at the clock
// edge of the release.
// Assumes: at most one admission and one release per cycle.
module vt_budget_gate #(
    parameter int N_RES       = 4,
    parameter int RIDW        = 2,
    parameter int REG_BUDGET  = 256,
    parameter int SMEM_BUDGET = 128,
    parameter int REG_W       = 9,
    parameter int SMEM_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [REG_W-1:0]  req_regs,
    input  logic [SMEM_W-1:0] req_smem,
    input  logic [N_RES-1:0]  free_mask,
    input  logic              rel_vld,
    input  logic [REG_W-1:0]  rel_regs,
    input  logic [SMEM_W-1:0] rel_smem,
    output logic              grant,
    output logic [RIDW-1:0]   grant_id
);
    localparam logic [REG_W:0]  REG_LIM  = (REG_W+1)'(REG_BUDGET);
    localparam logic [SMEM_W:0] SMEM_LIM = (SMEM_W+1)'(SMEM_BUDGET);

    logic [REG_W-1:0]  reg_used;
    logic [SMEM_W-1:0] smem_used;
    logic              any_free;
    logic              regs_fit;
    logic              smem_fit;

    // Lowest-index free resident entry.
    always_comb begin
        any_free = 1'b0;
        grant_id = '0;
        for (int i = 0; i < N_RES; i++) begin
            if (free_mask[i] && !any_free) begin
                any_free = 1'b1;
                grant_id = RIDW'(i);
            end
        end
    end

    // Budget check with one guard bit so the sum cannot wrap.
    always_comb begin
        regs_fit = ({1'b0, reg_used} + {1'b0, req_regs}) <= REG_LIM;
        smem_fit = ({1'b0, smem_used} + {1'b0, req_smem}) <= SMEM_LIM;
        grant    = req && any_free && regs_fit && smem_fit;
    end

    // Running totals: add the admitted demand, subtract the released one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_used  <= '0;
            smem_used <= '0;
        end else begin
            reg_used  <= reg_used + (grant ? req_regs : '0) - (rel_vld ? rel_regs : '0);
            smem_used <= smem_used + (grant ? req_smem : '0) - (rel_vld ? rel_smem : '0);
        end
    end

    // R3: the register total never goes past its budget.
    a_r3_regs_in_budget: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, reg_used} <= REG_LIM);

    // R3: the shared-memory total never goes past its budget.
    a_r3_smem_in_budget: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, smem_used} <= SMEM_LIM);

endmodule

// File: rtl/vt_age_pick.sv
// Age tracker and oldest-first picker. older[i][j] set means entry i was
// admitted before entry j. Among the candidate entries it returns the one
// that no other candidate is older than.
// Assumes: admissions are one per cycle, so any two resident entries have
// a defined order.
module vt_age_pick #(
    parameter int N_RES = 4,
    parameter int RIDW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             admit_vld,
    input  logic [RIDW-1:0]  admit_id,
    input  logic [N_RES-1:0] resident,
    input  logic [N_RES-1:0] cand,
    output logic             pick_vld,
    output logic [RIDW-1:0]  pick_id
);
    logic [N_RES-1:0] older [N_RES];

    // Select the candidate with no older candidate.
    always_comb begin
        pick_vld = 1'b0;
        pick_id  = '0;
        for (int i = 0; i < N_RES; i++) begin
            logic beaten;
            beaten = 1'b0;
            for (int j = 0; j < N_RES; j++) begin
                if (j != i && cand[j] && older[j][i]) beaten = 1'b1;
            end
            if (cand[i] && !beaten && !pick_vld) begin
                pick_vld = 1'b1;
                pick_id  = RIDW'(i);
            end
        end
    end

    // On admission every resident entry becomes older than the newcomer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_RES; i++) older[i] <= '0;
        end else if (admit_vld) begin
            for (int j = 0; j < N_RES; j++) begin
                older[j][admit_id] <= resident[j] && (RIDW'(j) != admit_id);
                older[admit_id][j] <= 1'b0;
            end
        end
    end

    // R5: a picked entry is always one of the ready candidates.
    a_r5_pick_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |-> cand[pick_id]);

endmodule

// File: rtl/vt_issue_slots.sv
// Issue-slot array. Each slot is empty, refilling or running. A slot wants
// a new occupant when it is empty, when its CTA completes, or when its
// running CTA has every warp stalled. The lowest slot that wants one
// receives the picked ready CTA; an evicted CTA is reported for parking.
// Assumes: pick_id is a parked CTA, never one that already holds a slot.
module vt_issue_slots
    import vt_sched_pkg::*;
#(
    parameter int N_ACT    = 2,
    parameter int N_RES    = 4,
    parameter int RIDW     = 2,
    parameter int SIDW     = 1,
    parameter int SWAP_CYC = 3,
    parameter int CNT_W    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_RES-1:0]      all_stalled,
    input  logic                  done_valid,
    input  logic [RIDW-1:0]       done_id,
    input  logic                  pick_vld,
    input  logic [RIDW-1:0]       pick_id,
    output logic [N_ACT-1:0]      act_valid,
    output logic [N_ACT*RIDW-1:0] act_id,
    output logic                  promote_vld,
    output logic                  demote_vld,
    output logic [RIDW-1:0]       demote_id
);
    slot_state_e      sst  [N_ACT];
    logic [RIDW-1:0]  sid  [N_ACT];
    logic [CNT_W-1:0] cnt  [N_ACT];
    logic [N_ACT-1:0] leaving;
    logic [N_ACT-1:0] evictable;
    logic [N_ACT-1:0] want;
    logic             win_vld;
    logic [SIDW-1:0]  win_idx;

    // Lowest-numbered slot that wants an occupant.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        for (int k = 0; k < N_ACT; k++) begin
            if (want[k] && !win_vld) begin
                win_vld = 1'b1;
                win_idx = SIDW'(k);
            end
        end
    end

    // One promotion per cycle; an evicted running CTA goes back to parking.
    always_comb begin
        promote_vld = pick_vld && win_vld;
        demote_vld  = promote_vld && evictable[win_idx];
        demote_id   = sid[win_idx];
    end

    for (genvar k = 0; k < N_ACT; k++) begin : g_slot
        // Per-slot demand: completion, full stall, or already empty.
        always_comb begin
            leaving[k]   = (sst[k] != SL_EMPTY) && done_valid && (done_id == sid[k]);
            evictable[k] = (sst[k] == SL_RUN) && all_stalled[sid[k]] && !leaving[k];
            want[k]      = (sst[k] == SL_EMPTY) || leaving[k] || evictable[k];
            act_valid[k] = (sst[k] == SL_RUN);
            act_id[k*RIDW +: RIDW] = sid[k];
        end

        // Slot state: take a promoted CTA, drop a completed one, count refill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sst[k] <= SL_EMPTY;
                sid[k] <= '0;
                cnt[k] <= '0;
            end else if (promote_vld && (win_idx == SIDW'(k))) begin
                sst[k] <= SL_REFILL;
                sid[k] <= pick_id;
                cnt[k] <= CNT_W'(SWAP_CYC - 1);
            end else if (leaving[k]) begin
                sst[k] <= SL_EMPTY;
            end else if (sst[k] == SL_REFILL) begin
                if (cnt[k] == '0) sst[k] <= SL_RUN;
                else              cnt[k] <= cnt[k] - 1'b1;
            end
        end

        // R7: a refilling slot stays hidden with the same CTA until its count ends.
        a_r7_refill_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (sst[k] == SL_REFILL && cnt[k] != '0 && !leaving[k])
            |=> (sst[k] == SL_REFILL && $stable(sid[k])));

        // R9: with nothing ready, a running slot keeps its CTA.
        a_r9_run_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (sst[k] == SL_RUN && !leaving[k] && !pick_vld)
            |=> (sst[k] == SL_RUN && $stable(sid[k])));

        // R6: a running CTA that is not fully stalled is never evicted.
        a_r6_only_stalled_leave: assert property (@(posedge clk) disable iff (!rst_n)
            (sst[k] == SL_RUN && !leaving[k] && !all_stalled[sid[k]])
            |=> (sst[k] == SL_RUN && $stable(sid[k])));
    end

    // R4: two occupied slots never hold the same resident index.
    for (genvar a = 0; a < N_ACT; a++) begin : g_pair_a
        for (genvar b = a + 1; b < N_ACT; b++) begin : g_pair_b
            a_r4_distinct_ids: assert property (@(posedge clk) disable iff (!rst_n)
                (sst[a] != SL_EMPTY && sst[b] != SL_EMPTY) |-> (sid[a] != sid[b]));
        end
    end

endmodule

// File: rtl/vt_cta_sched.sv
// Virtual CTA residency scheduler top. Holds the resident table (state and
// storage charge per CTA), derives per-CTA full-stall and readiness, and
// ties together the admission gate, the age picker and the issue slots.
// Assumes: warp_stall bits of free entries are ignored; done_id of a free
// entry is ignored; synchronous active-low reset.
module vt_cta_sched
    import vt_sched_pkg::*;
#(
    parameter int N_ACT       = 2,
    parameter int N_RES       = 4,
    parameter int WPC         = 2,
    parameter int REG_BUDGET  = 256,
    parameter int SMEM_BUDGET = 128,
    parameter int SWAP_CYC    = 3,
    localparam int RIDW   = $clog2(N_RES),
    localparam int SIDW   = (N_ACT > 1) ? $clog2(N_ACT) : 1,
    localparam int REG_W  = $clog2(REG_BUDGET + 1),
    localparam int SMEM_W = $clog2(SMEM_BUDGET + 1),
    localparam int CNT_W  = $clog2(SWAP_CYC + 1),
    localparam int NW     = N_RES * WPC
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch_req,
    input  logic [REG_W-1:0]      launch_regs,
    input  logic [SMEM_W-1:0]     launch_smem,
    output logic                  launch_grant,
    output logic [RIDW-1:0]       launch_id,
    input  logic [NW-1:0]         warp_stall,
    input  logic                  done_valid,
    input  logic [RIDW-1:0]       done_id,
    output logic [N_ACT-1:0]      act_valid,
    output logic [N_ACT*RIDW-1:0] act_id
);
    res_state_e        rstate   [N_RES];
    logic [REG_W-1:0]  regs_tab [N_RES];
    logic [SMEM_W-1:0] smem_tab [N_RES];

    logic [N_RES-1:0]  free_mask;
    logic [N_RES-1:0]  resident;
    logic [N_RES-1:0]  all_stalled;
    logic [N_RES-1:0]  cand;
    logic              done_hit;
    logic [REG_W-1:0]  rel_regs;
    logic [SMEM_W-1:0] rel_smem;
    logic              pick_vld;
    logic [RIDW-1:0]   pick_id;
    logic              promote_vld;
    logic              demote_vld;
    logic [RIDW-1:0]   demote_id;

    // A completion counts only for an occupied, in-range entry.
    always_comb begin
        done_hit = done_valid && (int'(done_id) < N_RES) && (rstate[done_id] != RS_FREE);
        rel_regs = regs_tab[done_id];
        rel_smem = smem_tab[done_id];
    end

    // Per-entry masks: free, resident, fully stalled, ready to promote.
    for (genvar i = 0; i < N_RES; i++) begin : g_res
        always_comb begin
            free_mask[i]   = (rstate[i] == RS_FREE);
            resident[i]    = (rstate[i] != RS_FREE);
            all_stalled[i] = &warp_stall[i*WPC +: WPC];
            cand[i]        = (rstate[i] == RS_PARK) && !all_stalled[i]
                             && !(done_hit && (done_id == RIDW'(i)));
        end

        // Entry state: completion first, then promotion, eviction, admission.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rstate[i]   <= RS_FREE;
                regs_tab[i] <= '0;
                smem_tab[i] <= '0;
            end else if (done_hit && (done_id == RIDW'(i))) begin
                rstate[i] <= RS_FREE;
            end else if (promote_vld && (pick_id == RIDW'(i))) begin
                rstate[i] <= RS_ISSUE;
            end else if (demote_vld && (demote_id == RIDW'(i))) begin
                rstate[i] <= RS_PARK;
            end else if (launch_grant && (launch_id == RIDW'(i))) begin
                rstate[i]   <= RS_PARK;
                regs_tab[i] <= launch_regs;
                smem_tab[i] <= launch_smem;
            end
        end
    end

    vt_budget_gate #(
        .N_RES       (N_RES),
        .RIDW        (RIDW),
        .REG_BUDGET  (REG_BUDGET),
        .SMEM_BUDGET (SMEM_BUDGET),
        .REG_W       (REG_W),
        .SMEM_W      (SMEM_W)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (launch_req),
        .req_regs  (launch_regs),
        .req_smem  (launch_smem),
        .free_mask (free_mask),
        .rel_vld   (done_hit),
        .rel_regs  (rel_regs),
        .rel_smem  (rel_smem),
        .grant     (launch_grant),
        .grant_id  (launch_id)
    );

    vt_age_pick #(
        .N_RES (N_RES),
        .RIDW  (RIDW)
    ) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .admit_vld (launch_grant),
        .admit_id  (launch_id),
        .resident  (resident),
        .cand      (cand),
        .pick_vld  (pick_vld),
        .pick_id   (pick_id)
    );

    vt_issue_slots #(
        .N_ACT    (N_ACT),
        .N_RES    (N_RES),
        .RIDW     (RIDW),
        .SIDW     (SIDW),
        .SWAP_CYC (SWAP_CYC),
        .CNT_W    (CNT_W)
    ) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .all_stalled (all_stalled),
        .done_valid  (done_hit),
        .done_id     (done_id),
        .pick_vld    (pick_vld),
        .pick_id     (pick_id),
        .act_valid   (act_valid),
        .act_id      (act_id),
        .promote_vld (promote_vld),
        .demote_vld  (demote_vld),
        .demote_id   (demote_id)
    );

    // R6: an evicted CTA is parked at the next edge, still resident.
    a_r6_evicted_parked: assert property (@(posedge clk) disable iff (!rst_n)
        demote_vld |=> (rstate[$past(demote_id)] == RS_PARK));

    // R8: a completed CTA's entry is free after the edge.
    a_r8_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        done_hit |=> (rstate[$past(done_id)] == RS_FREE));

    // R2: an admitted CTA is resident after the edge.
    a_r2_admit_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_grant && !done_hit) |=> (rstate[$past(launch_id)] == RS_PARK));

endmodule

// File: tb/tb_vt_cta_sched.sv
`timescale 1ns/1ps
module tb_vt_cta_sched;
    localparam int N_ACT = 2;
    localparam int RIDW  = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       launch_req;
    logic [8:0] launch_regs;
    logic [7:0] launch_smem;
    logic       launch_grant;
    logic [1:0] launch_id;
    logic [7:0] warp_stall;
    logic       done_valid;
    logic [1:0] done_id;
    logic [1:0] act_valid;
    logic [3:0] act_id;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vt_cta_sched dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_req   (launch_req),
        .launch_regs  (launch_regs),
        .launch_smem  (launch_smem),
        .launch_grant (launch_grant),
        .launch_id    (launch_id),
        .warp_stall   (warp_stall),
        .done_valid   (done_valid),
        .done_id      (done_id),
        .act_valid    (act_valid),
        .act_id       (act_id)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int slot_id(input int k);
        return int'(act_id[k*RIDW +: RIDW]);
    endfunction

    // R4: occupancy within limit and ids distinct among valid slots.
    task automatic chk_set(input string tag, input int vmask, input int id0, input int id1);
        chk({tag, " R4 valid mask"}, int'(act_valid), vmask);
        if (vmask[0]) chk({tag, " slot0 id"}, slot_id(0), id0);
        if (vmask[1]) chk({tag, " slot1 id"}, slot_id(1), id1);
        if (act_valid == 2'b11)
            chk({tag, " R4 distinct"}, int'(slot_id(0) != slot_id(1)), 1);
    endtask

    task automatic offer(input int regs, input int smem);
        launch_req  = 1'b1;
        launch_regs = 9'(regs);
        launch_smem = 8'(smem);
        #1;
    endtask

    task automatic t_reset();
        chk_set("R1 reset", 0, 0, 0);
        offer(10, 10);
        chk("R1 grant after reset", int'(launch_grant), 1);
        launch_req = 1'b0;
    endtask

    task automatic t_admit();
        offer(60, 20);
        chk("R2 first id", int'(launch_id), 0);
        step();
        offer(60, 20);
        chk("R2 second id", int'(launch_id), 1);
        step();
        offer(60, 20);
        chk("R2 third grant", int'(launch_grant), 1);
        chk("R2 third id", int'(launch_id), 2);
        step();
        launch_req = 1'b0;
        step(5);
        chk_set("R5 initial fill", 3, 0, 1);
    endtask

    task automatic t_no_ready();
        warp_stall = 8'h3F;
        step(3);
        chk_set("R9 all stalled mid", 3, 0, 1);
        step(3);
        chk_set("R9 all stalled end", 3, 0, 1);
    endtask

    task automatic t_swap();
        warp_stall = 8'h1F;
        step();
        chk_set("R7 swap hidden 1", 2, 0, 1);
        step();
        chk_set("R7 swap hidden 2", 2, 0, 1);
        step();
        chk_set("R7 swap hidden 3", 2, 0, 1);
        step();
        chk_set("R6 swapped in", 3, 2, 1);
    endtask

    task automatic t_budget();
        offer(10, 69);
        chk("R3 smem over", int'(launch_grant), 0);
        offer(77, 10);
        chk("R3 regs over (evicted CTA still charged R6)", int'(launch_grant), 0);
        offer(76, 68);
        chk("R2 exact fit", int'(launch_grant), 1);
        chk("R2 exact fit id", int'(launch_id), 3);
        step();
        launch_req = 1'b0;
        step();
        chk_set("R6 second swap hidden", 1, 2, 0);
        step(3);
        chk_set("R5 second swap done", 3, 2, 3);
    endtask

    task automatic t_done();
        warp_stall = 8'h00;
        step(2);
        chk_set("R6 no stall no swap", 3, 2, 3);
        done_valid = 1'b1;
        done_id    = 2'd2;
        step();
        done_valid = 1'b0;
        chk_set("R8 slot refilling", 2, 0, 3);
        offer(60, 20);
        chk("R8 storage reused", int'(launch_grant), 1);
        chk("R8 freed id", int'(launch_id), 2);
        step();
        launch_req = 1'b0;
        step(2);
        chk_set("R5 oldest promoted", 3, 0, 3);
    endtask

    task automatic t_full_and_park_done();
        offer(1, 0);
        chk("R3 no free entry", int'(launch_grant), 0);
        launch_req = 1'b0;
        done_valid = 1'b1;
        done_id    = 2'd1;
        step();
        done_valid = 1'b0;
        chk_set("R8 parked done", 3, 0, 3);
        offer(1, 0);
        chk("R8 entry reusable", int'(launch_grant), 1);
        chk("R8 entry id", int'(launch_id), 1);
        step();
        launch_req = 1'b0;
        chk_set("R8 set unchanged", 3, 0, 3);
    endtask

    task automatic t_one_per_cycle();
        warp_stall = 8'hC3;
        step();
        chk_set("R10 lowest slot first", 2, 0, 3);
        step();
        chk_set("R10 second slot next", 0, 0, 0);
        step(2);
        chk_set("R10 slot0 runs oldest", 1, 2, 0);
        step();
        chk_set("R10 slot1 runs", 3, 2, 1);
    endtask

    initial begin
        rst_n       = 1'b0;
        launch_req  = 1'b0;
        launch_regs = '0;
        launch_smem = '0;
        warp_stall  = '0;
        done_valid  = 1'b0;
        done_id     = '0;
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_admit();
        t_no_ready();
        t_swap();
        t_budget();
        t_done();
        t_full_and_park_done();
        t_one_per_cycle();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule